// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves one virtual address into a physical page number by walking a four-level translation table held in ordinary memory. A 48-bit virtual address carries four 9-bit table indices above a 12-bit page offset. The first index selects an entry in the top-level table, whose 4 KB-aligned base comes from a root page-number input. Each entry that is present supplies the base of the next table, and the fourth entry supplies the page itself. The walker reads one 64-bit entry per level and checks its permission bits against the access type, so a restricted upper-level entry can block a walk early.

While it walks, the walker keeps the accessed flag of each entry it passes and the dirty flag of the final entry. It writes an entry back only when one of those flags actually changes, and it does so before the next read or the response. The response carries either the physical page number, the full physical address and the execute-disable flag, or a fault cause with the level at which the walk stopped. One walk is handled at a time. A request that arrives while a walk is in progress is not taken.

Top module: `page_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, and neither memory strobe is active.
- R2: Each entry read uses address {table base, index, 3'b000}. The level-1 base is `root_ppn`, and the index for level k (k = 1..4) is `req_va[47-9(k-1) -: 9]`. Each later base is entry bits [51:12].
- R3: A walk that succeeds issues exactly four entry reads. Only one read is outstanding at a time, and a read strobe never coincides with a write strobe.
- R4: An entry with bit 0 (present) clear ends the walk with `rsp_cause` = 1. `rsp_level` then gives the failing level as 0 for the top level through 3 for the last.
- R5: A write access that meets an entry with bit 1 clear (read-only) ends the walk with `rsp_cause` = 2 at that level.
- R6: A user access that meets an entry with bit 2 clear (supervisor only) ends the walk with `rsp_cause` = 3 at that level. The causes rank not-present first, then write, then privilege.
- R7: If bit 5 (accessed) of a read entry is clear, the entry is written back to the same address with bit 5 set. On a write access, bit 6 (dirty) of the level-4 entry is also set. The write-back happens before the next read or the response.
- R8: An entry whose accessed bit (and dirty bit, for writes at level 4) is already set is not written back.
- R9: On success, `rsp_fault` is 0, `rsp_cause` is 0, `rsp_ppn` is bits [51:12] of the level-4 entry, `rsp_pa` is {`rsp_ppn`, `req_va[11:0]`}, and `rsp_xd` is bit 63 of that entry.
- R10: An entry that causes a fault is not written back.
- R11: `rsp_valid` is high for one cycle per walk. `req_ready` is low from acceptance until after the response. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | 40 | Page number of the level-1 table |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_va | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_rd_en | output | 1 | One-cycle entry read strobe |
| mem_wr_en | output | 1 | One-cycle entry write-back strobe |
| mem_addr | output | 52 | Entry physical address |
| mem_wdata | output | 64 | Entry value written back |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Entry value read |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write to read-only, 3 user on supervisor |
| rsp_level | output | 2 | Level of the faulting entry, 0 = top |
| rsp_ppn | output | 40 | Translated page number |
| rsp_pa | output | 52 | Translated physical address |
| rsp_xd | output | 1 | Execute-disable flag of the final entry |

## Verification
Assertions check the handshake and strobe rules on every cycle. The read and write strobes are never active together, a read is never issued on back-to-back cycles, a response lasts one cycle and never occurs while ready, a write-back keeps the address of its read and carries the accessed bit, and a faulting response never directly follows a write-back. Only the bench scenarios show the translation results, the choice of fault cause and level, and whether flags are written back. These depend on the table contents the bench builds and on state left by earlier walks, such as a dirty bit set on the first write and not rewritten on the second. The bench also shows the exact entry addresses under a slow memory and that a request made while busy is dropped.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 40,
  parameter int PTE_W  = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [PPN_W-1:0]                root_ppn,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [LEVELS*IDX_W+OFF_W-1:0]   req_va,
  input  logic                            req_write,
  input  logic                            req_user,
  output logic                            mem_rd_en,
  output logic                            mem_wr_en,
  output logic [PPN_W+OFF_W-1:0]          mem_addr,
  output logic [PTE_W-1:0]                mem_wdata,
  input  logic                            mem_rvalid,
  input  logic [PTE_W-1:0]                mem_rdata,
  output logic                            rsp_valid,
  output logic                            rsp_fault,
  output logic [1:0]                      rsp_cause,
  output logic [$clog2(LEVELS)-1:0]       rsp_level,
  output logic [PPN_W-1:0]                rsp_ppn,
  output logic [PPN_W+OFF_W-1:0]          rsp_pa,
  output logic                            rsp_xd
);
  localparam int VA_W  = LEVELS*IDX_W + OFF_W;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int ENT_W = OFF_W - IDX_W;
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6;
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS-1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_WB, S_DONE} st_t;

  st_t               state;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, usr_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PPN_W-1:0]  base_q;
  logic [PTE_W-1:0]  pte_q;
  logic [1:0]        cause_q;
  logic [LVL_W-1:0]  flvl_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              xd_q;

  logic [IDX_W-1:0]  idx;
  logic              last;
  logic [1:0]        cause;
  logic [PTE_W-1:0]  upd;
  logic              step;
  logic [PTE_W-1:0]  nxt;

  assign idx  = va_q[OFF_W + (LEVELS-1-int'(lvl_q))*IDX_W +: IDX_W];
  assign last = (lvl_q == LAST);

  always_comb begin
    if (!mem_rdata[B_P])                 cause = 2'd1;
    else if (wr_q && !mem_rdata[B_RW])   cause = 2'd2;
    else if (usr_q && !mem_rdata[B_US])  cause = 2'd3;
    else                                 cause = 2'd0;
    upd = mem_rdata;
    upd[B_A] = 1'b1;
    if (last && wr_q) upd[B_D] = 1'b1;
  end

  assign step = (state == S_WB) ||
                (state == S_WAIT && mem_rvalid && cause == 2'd0 && upd == mem_rdata);
  assign nxt  = (state == S_WB) ? pte_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      cause_q <= '0;
      flvl_q  <= '0;
      ppn_q   <= '0;
      xd_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          usr_q  <= req_user;
          lvl_q  <= '0;
          base_q <= root_ppn;
          state  <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (cause != 2'd0) begin
            cause_q <= cause;
            flvl_q  <= lvl_q;
            ppn_q   <= '0;
            xd_q    <= 1'b0;
            state   <= S_DONE;
          end else if (upd != mem_rdata) begin
            pte_q <= upd;
            state <= S_WB;
          end
        end
        S_DONE: state <= S_IDLE;
        default: ;
      endcase
      if (step) begin
        if (last) begin
          cause_q <= 2'd0;
          flvl_q  <= '0;
          ppn_q   <= nxt[OFF_W +: PPN_W];
          xd_q    <= nxt[PTE_W-1];
          state   <= S_DONE;
        end else begin
          lvl_q  <= lvl_q + 1'b1;
          base_q <= nxt[OFF_W +: PPN_W];
          state  <= S_ISSUE;
        end
      end
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_rd_en = (state == S_ISSUE);
  assign mem_wr_en = (state == S_WB);
  assign mem_addr  = {base_q, idx, {ENT_W{1'b0}}};
  assign mem_wdata = pte_q;
  assign rsp_valid = (state == S_DONE);
  assign rsp_fault = (cause_q != 2'd0);
  assign rsp_cause = cause_q;
  assign rsp_level = flvl_q;
  assign rsp_ppn   = ppn_q;
  assign rsp_pa    = {ppn_q, va_q[OFF_W-1:0]};
  assign rsp_xd    = xd_q;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_wb_sets_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[B_A]);
  assert_wb_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $stable(mem_addr));
  assert_fault_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !$past(mem_wr_en));
endmodule

// File: tb/page_walker_tb.sv
module page_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [39:0]  root_ppn = 40'd1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [47:0]  req_va = '0;
  logic         req_write = 1'b0;
  logic         req_user = 1'b0;
  logic         mem_rd_en, mem_wr_en;
  logic [51:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic         mem_rvalid;
  logic [63:0]  mem_rdata;
  logic         rsp_valid, rsp_fault, rsp_xd;
  logic [1:0]   rsp_cause, rsp_level;
  logic [39:0]  rsp_ppn;
  logic [51:0]  rsp_pa;

  int checks = 0;
  int errors = 0;
  int lat = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_level(rsp_level), .rsp_ppn(rsp_ppn), .rsp_pa(rsp_pa), .rsp_xd(rsp_xd)
  );

  function automatic logic [63:0] pte(input logic [39:0] b, input logic [63:0] fl);
    return fl | {12'd0, b, 12'd0};
  endfunction

  logic [63:0] mem [0:4095];
  logic        pend;
  int          cnt;
  logic [51:0] paddr;
  int          nrd, nwr;
  logic [51:0] rlog [0:3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      mem[1*512+0] <= pte(40'd2, 64'h7);
      mem[1*512+2] <= pte(40'd2, 64'h5);
      mem[1*512+3] <= pte(40'd2, 64'h3);
      mem[2*512+0] <= pte(40'd3, 64'h7);
      mem[3*512+0] <= pte(40'd4, 64'h7);
      mem[4*512+0] <= pte(40'h12345, 64'h7);
      mem[4*512+2] <= pte(40'h777, 64'h5);
      mem[4*512+3] <= pte(40'h333, 64'h3);
      mem[4*512+4] <= pte(40'hABC, 64'h8000_0000_0000_0027);
      pend <= 1'b0; cnt <= 0; paddr <= '0;
      nrd <= 0; nwr <= 0;
      mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_rd_en) begin
        pend <= 1'b1; cnt <= lat; paddr <= mem_addr;
        rlog[nrd % 4] <= mem_addr;
        nrd <= nrd + 1;
      end else if (pend) begin
        if (cnt <= 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[paddr[14:3]];
          pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
      if (mem_wr_en) begin
        mem[mem_addr[14:3]] <= mem_wdata;
        nwr <= nwr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [47:0] va, input logic wr, input logic usr);
    @(negedge clk);
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  function automatic logic [47:0] mkva(input logic [8:0] v1, input logic [8:0] v4, input logic [11:0] off);
    return {v1, 9'd0, 9'd0, v4, off};
  endfunction

  // {vpn1, vpn4, write, user, cause, level, xd, ppn, write-backs}
  localparam logic [67:0] VEC [NV] = '{
    {9'd0, 9'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 40'h12345, 3'd4},
    {9'd0, 9'd0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 40'h12345, 3'd1},
    {9'd0, 9'd0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 40'h12345, 3'd0},
    {9'd0, 9'd1, 1'b0, 1'b0, 2'd1, 2'd3, 1'b0, 40'h0,     3'd0},
    {9'd0, 9'd2, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 40'h777,   3'd1},
    {9'd0, 9'd2, 1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 40'h0,     3'd0},
    {9'd0, 9'd3, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 40'h0,     3'd0},
    {9'd0, 9'd3, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 40'h333,   3'd1},
    {9'd0, 9'd4, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 40'hABC,   3'd0},
    {9'd1, 9'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 40'h0,     3'd0},
    {9'd2, 9'd0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 40'h0,     3'd0},
    {9'd2, 9'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 40'h12345, 3'd1},
    {9'd3, 9'd0, 1'b0, 1'b1, 2'd3, 2'd0, 1'b0, 40'h0,     3'd0},
    {9'd0, 9'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 40'h12345, 3'd0}
  };

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 ready/valid in reset", {req_ready, rsp_valid}, 2'b10);
    chk(mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R1 strobes in reset", {mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 after reset", {req_ready, rsp_valid}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      logic [47:0] va;
      int w0, r0;
      v  = VEC[i];
      va = mkva(v[67:59], v[58:50], 12'h3C0 ^ 12'(i));
      w0 = nwr; r0 = nrd;
      walk(va, v[49], v[48]);
      chk(rsp_cause === v[47:46], $sformatf("R4 R5 R6 cause vec %0d", i), rsp_cause, v[47:46]);
      chk(rsp_fault === (v[47:46] != 0), $sformatf("R9 fault flag vec %0d", i), rsp_fault, v[47:46] != 0);
      if (v[47:46] != 0)
        chk(rsp_level === v[45:44], $sformatf("R4 level vec %0d", i), rsp_level, v[45:44]);
      else begin
        chk(rsp_ppn === v[42:3], $sformatf("R9 ppn vec %0d", i), rsp_ppn, v[42:3]);
        chk(rsp_pa === {v[42:3], va[11:0]}, $sformatf("R9 pa vec %0d", i), rsp_pa, {v[42:3], va[11:0]});
        chk(rsp_xd === v[43], $sformatf("R9 xd vec %0d", i), rsp_xd, v[43]);
        chk(nrd - r0 == 4, $sformatf("R3 read count vec %0d", i), nrd - r0, 4);
      end
      chk(nwr - w0 == int'(v[2:0]), $sformatf("R7 R8 R10 write-backs vec %0d", i), nwr - w0, v[2:0]);
    end

    // R7 flags in memory after writes
    chk(mem[4*512+0][6:5] === 2'b11, "R7 level-4 dirty+accessed", mem[4*512+0][6:5], 2'b11);
    chk(mem[3*512+0][6] === 1'b0 && mem[3*512+0][5] === 1'b1, "R7 upper entry accessed only", mem[3*512+0][6:5], 2'b01);
    chk(mem[4*512+2][5] === 1'b1, "R7 accessed set on read", mem[4*512+2][5], 1);
    chk(mem[1*512+3][5] === 1'b0, "R10 faulting entry untouched", mem[1*512+3][5], 0);

    // R2 entry addresses with slow memory, R11 busy requests ignored
    lat = 5;
    begin
      int r0;
      logic [47:0] va;
      r0 = nrd;
      va = mkva(9'd2, 9'd3, 12'h55A);
      @(negedge clk);
      req_va = va; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b0, "R11 ready low while busy", req_ready, 0);
      req_va = mkva(9'd1, 9'd0, 12'h0);
      req_user = 1'b1;
      while (!rsp_valid) @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_fault === 1'b0 && rsp_ppn === 40'h333, "R11 busy request ignored", rsp_ppn, 40'h333);
      chk(rsp_pa[11:0] === 12'h55A, "R9 offset slow memory", rsp_pa[11:0], 12'h55A);
      chk(rlog[(r0+0)%4] === 52'h1010, "R2 level-1 address", rlog[(r0+0)%4], 52'h1010);
      chk(rlog[(r0+1)%4] === 52'h2000, "R2 level-2 address", rlog[(r0+1)%4], 52'h2000);
      chk(rlog[(r0+2)%4] === 52'h3000, "R2 level-3 address", rlog[(r0+2)%4], 52'h3000);
      chk(rlog[(r0+3)%4] === 52'h4018, "R2 level-4 address", rlog[(r0+3)%4], 52'h4018);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R11 response one cycle", rsp_valid, 0);
      repeat (4) @(negedge clk);
      chk(nrd - r0 == 4, "R11 no walk after busy request", nrd - r0, 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule